// File: doc/BRIEF.md
# Multiprocessor System Interrupt Router

This block collects up to 32 device interrupt lines into a system pending word, filters that word through a per-source disable mask, and steers whatever survives to a single processor chosen by software. Every source bit goes through a build-time table that assigns it a processor priority level from 1 to 15. Entries at level 0 mark lines that are not wired, and the block ignores them. For each of up to 16 processors the block drives a 15-bit level-request vector. Bit L-1 of that vector requests level L.

Each processor's vector is the OR of two parts. The first is the system levels, present only on the selected target. The second is the processor's software-interrupt bits, which come from a separate per-processor register block through `soft_i`. Each processor also has a private timer line. The timer line raises a designated system source bit and marks that processor's own hardware pending bit at the timer's level. The hardware pending bits of every processor are brought out on `cpu_hw_pend_o` so the per-processor block can present them.

Software reaches the system state through a word-addressed port. Reads return data one cycle after the address is presented. A write takes effect at the clock edge where `bus_we` is sampled high.

Top module: `irt_router`

## Requirements
- R1: After reset the pending word is zero and the target is 0. The disable word holds 0x0FA2007F, so every implemented bit (mask 0xF05DFF80) reads as enabled. All level and hardware pending outputs are zero.
- R2: A read of word offset 0 returns the system pending word with bit 31 forced to zero.
- R3: A read of word offset 1 returns the disable word ANDed with 0xF05DFF80. Bits outside that mask stay disabled permanently.
- R4: A write to offset 2 clears the written disable bits within 0xF05DFF80, which enables those sources. It does not touch the pending word.
- R5: A write to offset 3 sets the written disable bits within 0xF05DFF80 and clears the same bits of the pending word.
- R6: Offset 4 writes and reads the target processor number. Only the low 4 bits are kept.
- R7: System levels reach only the target processor's vector. They appear only when some bit is pending and not disabled, and disable bit 31 (the global disable) is clear.
- R8: Default level map: bits 0 and 31 have level 0, and bit j (1..30) has level ((j-1) mod 15)+1. A source at level 0 never sets a pending bit and never changes any output.
- R9: A rising source line sets its pending bit and sets the bit for its level in the current target's hardware pending vector. A falling line clears both.
- R10: Each processor's level vector includes that processor's `soft_i` lane (bit L-1 = level L), whoever the target is and whatever the disable state.
- R11: A rising timer line c sets system pending bit 14 (default) and bit 13 (level 14) of processor c's hardware pending vector. A falling timer line clears both.
- R12: Outputs are registered. A source, timer, soft or register-write change sampled at one clock edge shows on the outputs after that same edge, and not before it.
- R13: If a source rises in the same cycle as an offset-3 write covering its bit, the write wins and the pending bit ends up clear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_i | input | 32 | Device interrupt lines, level sensitive |
| tmr_i | input | NUM_CPUS | Per-processor timer lines |
| soft_i | input | NUM_CPUS*15 | Per-processor software levels, 15-bit lanes |
| bus_addr | input | 3 | Word offset of the register port |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data for the previous cycle's address |
| lvl_o | output | NUM_CPUS*15 | Per-processor level-request vectors |
| cpu_hw_pend_o | output | NUM_CPUS*15 | Per-processor hardware pending bits, bit L-1 = level L |

## Verification
The bound checker watches properties that hold cycle by cycle. Unimplemented disable bits stay set. Offset-0 reads never show bit 31. Each register write lands with its masking, and an offset-3 write clears pending. A global disable, or a processor not being the target, leaves that vector equal to its software lane. The bench's scenarios are what demonstrate the mapping of individual source bits to levels, and the edge-driven set and clear of the target's and the timer owner's hardware pending bits. They also show that enabling a source does not revive pending state that a disable already erased, and that an offset-3 write beats a source rise in the same cycle.

// File: rtl/irt_pkg.sv
package irt_pkg;
  localparam int SRC_N  = 32;
  localparam int LVL_N  = 15;
  localparam int LVL_W  = 4;
  localparam int GDIS_BIT = 31;
  localparam logic [SRC_N-1:0] IMPL_MASK = 32'hF05D_FF80;
  localparam logic [SRC_N-1:0] DIS_RST   = 32'h0FA2_007F;

  typedef enum logic [2:0] {
    OFS_PEND = 3'd0,
    OFS_DIS  = 3'd1,
    OFS_ENA  = 3'd2,
    OFS_MSK  = 3'd3,
    OFS_TGT  = 3'd4
  } reg_ofs_e;

  // bits 0 and 31 unmapped; others cycle through levels 1..15
  function automatic logic [SRC_N*LVL_W-1:0] default_lvl_map();
    logic [SRC_N*LVL_W-1:0] m;
    m = '0;
    for (int j = 1; j < SRC_N - 1; j++) begin
      m[j*LVL_W +: LVL_W] = LVL_W'(((j - 1) % LVL_N) + 1);
    end
    return m;
  endfunction

  function automatic logic [LVL_N-1:0] lvl_onehot(logic [LVL_W-1:0] l);
    logic [LVL_N-1:0] v;
    v = '0;
    if (l != '0) v[int'(l) - 1] = 1'b1;
    return v;
  endfunction
endpackage

// File: rtl/irt_edge.sv
module irt_edge #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] in_i,
  output logic [W-1:0] rise_o,
  output logic [W-1:0] fall_o
);
  logic [W-1:0] q;

  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= in_i;
  end

  assign rise_o = in_i & ~q;
  assign fall_o = ~in_i & q;
endmodule

// File: rtl/irt_lvl_fold.sv
module irt_lvl_fold import irt_pkg::*; #(
  parameter logic [SRC_N*LVL_W-1:0] LEVEL_MAP = default_lvl_map()
) (
  input  logic [SRC_N-1:0] bits_i,
  output logic [LVL_N-1:0] lvls_o
);
  always_comb begin
    lvls_o = '0;
    for (int j = 0; j < SRC_N; j++) begin
      if (bits_i[j]) lvls_o = lvls_o | lvl_onehot(LEVEL_MAP[j*LVL_W +: LVL_W]);
    end
  end
endmodule

// File: rtl/irt_sys_regs.sv
module irt_sys_regs import irt_pkg::*; #(
  parameter int TGT_W = 4,
  parameter logic [SRC_N*LVL_W-1:0] LEVEL_MAP = default_lvl_map(),
  parameter int TIMER_BIT = 14
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SRC_N-1:0] src_rise,
  input  logic [SRC_N-1:0] src_fall,
  input  logic             tmr_any_rise,
  input  logic             tmr_any_fall,
  input  logic [2:0]       bus_addr,
  input  logic             bus_we,
  input  logic [31:0]      bus_wdata,
  output logic [31:0]      bus_rdata,
  output logic [SRC_N-1:0] pend_q,
  output logic [SRC_N-1:0] dis_q,
  output logic [TGT_W-1:0] tgt_q,
  output logic [SRC_N-1:0] pend_n,
  output logic [SRC_N-1:0] dis_n,
  output logic [TGT_W-1:0] tgt_n
);
  logic [SRC_N-1:0] live;
  logic [SRC_N-1:0] set_ev, clr_ev, wmask;

  for (genvar j = 0; j < SRC_N; j++) begin : g_live
    assign live[j] = (LEVEL_MAP[j*LVL_W +: LVL_W] != '0);
  end

  assign wmask  = bus_wdata & IMPL_MASK;
  assign set_ev = (src_rise & live) | (SRC_N'(tmr_any_rise) << TIMER_BIT);
  assign clr_ev = (src_fall & live) | (SRC_N'(tmr_any_fall) << TIMER_BIT);

  always_comb begin
    pend_n = (pend_q & ~clr_ev) | set_ev;
    dis_n  = dis_q;
    tgt_n  = tgt_q;
    if (bus_we) begin
      case (reg_ofs_e'(bus_addr))
        OFS_ENA: dis_n = dis_q & ~wmask;
        OFS_MSK: begin
          dis_n  = dis_q | wmask;
          pend_n = pend_n & ~wmask;
        end
        OFS_TGT: tgt_n = bus_wdata[TGT_W-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q    <= '0;
      dis_q     <= DIS_RST;
      tgt_q     <= '0;
      bus_rdata <= '0;
    end else begin
      pend_q <= pend_n;
      dis_q  <= dis_n;
      tgt_q  <= tgt_n;
      case (reg_ofs_e'(bus_addr))
        OFS_PEND: bus_rdata <= pend_q & ~(32'd1 << GDIS_BIT);
        OFS_DIS:  bus_rdata <= dis_q & IMPL_MASK;
        OFS_TGT:  bus_rdata <= {{(32-TGT_W){1'b0}}, tgt_q};
        default:  bus_rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/irt_cpu_lane.sv
module irt_cpu_lane import irt_pkg::*; (
  input  logic             clk,
  input  logic             rst,
  input  logic             is_tgt_now,
  input  logic             is_tgt_next,
  input  logic [LVL_N-1:0] src_set_lvls,
  input  logic [LVL_N-1:0] src_clr_lvls,
  input  logic             tmr_rise,
  input  logic             tmr_fall,
  input  logic [LVL_N-1:0] tmr_lvl,
  input  logic             route_en,
  input  logic [LVL_N-1:0] route_lvls,
  input  logic [LVL_N-1:0] soft_lvls,
  output logic [LVL_N-1:0] hw_pend_q,
  output logic [LVL_N-1:0] lvl_q
);
  logic [LVL_N-1:0] set_v, clr_v, hw_n, lvl_n;

  always_comb begin
    set_v = (is_tgt_now ? src_set_lvls : '0) | (tmr_rise ? tmr_lvl : '0);
    clr_v = (is_tgt_now ? src_clr_lvls : '0) | (tmr_fall ? tmr_lvl : '0);
    hw_n  = (hw_pend_q & ~clr_v) | set_v;
    lvl_n = ((is_tgt_next && route_en) ? route_lvls : '0) | soft_lvls;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hw_pend_q <= '0;
      lvl_q     <= '0;
    end else begin
      hw_pend_q <= hw_n;
      lvl_q     <= lvl_n;
    end
  end
endmodule

// File: rtl/irt_router.sv
module irt_router import irt_pkg::*; #(
  parameter int NUM_CPUS  = 16,
  parameter int TGT_W     = 4,
  parameter logic [SRC_N*LVL_W-1:0] LEVEL_MAP = default_lvl_map(),
  parameter int TIMER_BIT = 14
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [SRC_N-1:0]          src_i,
  input  logic [NUM_CPUS-1:0]       tmr_i,
  input  logic [NUM_CPUS*LVL_N-1:0] soft_i,
  input  logic [2:0]                bus_addr,
  input  logic                      bus_we,
  input  logic [31:0]               bus_wdata,
  output logic [31:0]               bus_rdata,
  output logic [NUM_CPUS*LVL_N-1:0] lvl_o,
  output logic [NUM_CPUS*LVL_N-1:0] cpu_hw_pend_o
);
  localparam logic [LVL_N-1:0] TMR_LVL = lvl_onehot(LEVEL_MAP[TIMER_BIT*LVL_W +: LVL_W]);

  logic [SRC_N-1:0]    src_rise, src_fall;
  logic [NUM_CPUS-1:0] tmr_rise, tmr_fall;
  logic [SRC_N-1:0]    pend_q, dis_q, pend_n, dis_n, eff_n;
  logic [TGT_W-1:0]    tgt_q, tgt_n;
  logic [LVL_N-1:0]    route_lvls, set_lvls, clr_lvls;
  logic                route_en;

  irt_edge #(.W(SRC_N)) u_src_edge (
    .clk(clk), .rst(rst), .in_i(src_i), .rise_o(src_rise), .fall_o(src_fall)
  );

  irt_edge #(.W(NUM_CPUS)) u_tmr_edge (
    .clk(clk), .rst(rst), .in_i(tmr_i), .rise_o(tmr_rise), .fall_o(tmr_fall)
  );

  irt_sys_regs #(.TGT_W(TGT_W), .LEVEL_MAP(LEVEL_MAP), .TIMER_BIT(TIMER_BIT)) u_regs (
    .clk(clk), .rst(rst),
    .src_rise(src_rise), .src_fall(src_fall),
    .tmr_any_rise(|tmr_rise), .tmr_any_fall(|tmr_fall),
    .bus_addr(bus_addr), .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pend_q(pend_q), .dis_q(dis_q), .tgt_q(tgt_q),
    .pend_n(pend_n), .dis_n(dis_n), .tgt_n(tgt_n)
  );

  assign eff_n    = pend_n & ~dis_n;
  assign route_en = (|eff_n) && !dis_n[GDIS_BIT];

  irt_lvl_fold #(.LEVEL_MAP(LEVEL_MAP)) u_fold_route (.bits_i(eff_n),    .lvls_o(route_lvls));
  irt_lvl_fold #(.LEVEL_MAP(LEVEL_MAP)) u_fold_set   (.bits_i(src_rise), .lvls_o(set_lvls));
  irt_lvl_fold #(.LEVEL_MAP(LEVEL_MAP)) u_fold_clr   (.bits_i(src_fall), .lvls_o(clr_lvls));

  for (genvar c = 0; c < NUM_CPUS; c++) begin : g_lane
    irt_cpu_lane u_lane (
      .clk(clk), .rst(rst),
      .is_tgt_now(tgt_q == TGT_W'(c)),
      .is_tgt_next(tgt_n == TGT_W'(c)),
      .src_set_lvls(set_lvls), .src_clr_lvls(clr_lvls),
      .tmr_rise(tmr_rise[c]), .tmr_fall(tmr_fall[c]), .tmr_lvl(TMR_LVL),
      .route_en(route_en), .route_lvls(route_lvls),
      .soft_lvls(soft_i[c*LVL_N +: LVL_N]),
      .hw_pend_q(cpu_hw_pend_o[c*LVL_N +: LVL_N]),
      .lvl_q(lvl_o[c*LVL_N +: LVL_N])
    );
  end
endmodule

// File: rtl/irt_router_chk.sv
module irt_router_chk import irt_pkg::*; #(
  parameter int NUM_CPUS = 16,
  parameter int TGT_W    = 4
) (
  input logic                      clk,
  input logic                      rst,
  input logic [NUM_CPUS*LVL_N-1:0] soft_i,
  input logic [2:0]                bus_addr,
  input logic                      bus_we,
  input logic [31:0]               bus_wdata,
  input logic [31:0]               bus_rdata,
  input logic [NUM_CPUS*LVL_N-1:0] lvl_o,
  input logic [SRC_N-1:0]          pend_q,
  input logic [SRC_N-1:0]          dis_q,
  input logic [TGT_W-1:0]          tgt_q
);
  logic past_ok;
  always_ff @(posedge clk) begin
    if (rst) past_ok <= 1'b0;
    else     past_ok <= 1'b1;
  end

  p_rd_bit31_r2: assert property (@(posedge clk) disable iff (rst)
    (bus_addr == 3'd0) |=> !bus_rdata[31]);

  p_unimpl_dis_r3: assert property (@(posedge clk) disable iff (rst)
    (dis_q & ~IMPL_MASK) == ~IMPL_MASK);

  p_enable_wr_r4: assert property (@(posedge clk) disable iff (rst)
    (bus_we && bus_addr == 3'd2) |=> ((dis_q & $past(bus_wdata) & IMPL_MASK) == '0));

  p_mask_wr_r5: assert property (@(posedge clk) disable iff (rst)
    (bus_we && bus_addr == 3'd3) |=>
      (((dis_q & $past(bus_wdata) & IMPL_MASK) == ($past(bus_wdata) & IMPL_MASK)) &&
       ((pend_q & $past(bus_wdata) & IMPL_MASK) == '0)));

  p_tgt_wr_r6: assert property (@(posedge clk) disable iff (rst)
    (bus_we && bus_addr == 3'd4) |=> (tgt_q == $past(bus_wdata[TGT_W-1:0])));

  for (genvar c = 0; c < NUM_CPUS; c++) begin : g_lane_chk
    p_gdis_r7: assert property (@(posedge clk) disable iff (rst)
      (past_ok && dis_q[GDIS_BIT]) |->
        (lvl_o[c*LVL_N +: LVL_N] == $past(soft_i[c*LVL_N +: LVL_N])));

    p_non_target_r10: assert property (@(posedge clk) disable iff (rst)
      (past_ok && tgt_q != TGT_W'(c)) |->
        (lvl_o[c*LVL_N +: LVL_N] == $past(soft_i[c*LVL_N +: LVL_N])));
  end
endmodule

bind irt_router irt_router_chk #(.NUM_CPUS(NUM_CPUS), .TGT_W(TGT_W)) u_chk (
  .clk(clk), .rst(rst), .soft_i(soft_i),
  .bus_addr(bus_addr), .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
  .lvl_o(lvl_o), .pend_q(pend_q), .dis_q(dis_q), .tgt_q(tgt_q)
);

// File: tb/irt_router_tb.sv
module irt_router_tb;
  localparam int NC = 16;
  localparam int LN = 15;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [31:0]       src_i = '0;
  logic [NC-1:0]     tmr_i = '0;
  logic [NC*LN-1:0]  soft_i = '0;
  logic [2:0]        bus_addr = '0;
  logic              bus_we = 1'b0;
  logic [31:0]       bus_wdata = '0;
  logic [31:0]       bus_rdata;
  logic [NC*LN-1:0]  lvl_o, cpu_hw_pend_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  irt_router u_dut (
    .clk(clk), .rst(rst), .src_i(src_i), .tmr_i(tmr_i), .soft_i(soft_i),
    .bus_addr(bus_addr), .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .lvl_o(lvl_o), .cpu_hw_pend_o(cpu_hw_pend_o)
  );

  // R8 default map, computed independently
  function automatic logic [31:0] lbit(int j);
    if (j == 0 || j == 31) return 32'd0;
    return 32'd1 << (((j - 1) % 15));
  endfunction

  function automatic logic [31:0] lane(logic [NC*LN-1:0] v, int c);
    return {17'd0, v[c*LN +: LN]};
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d);
    bus_addr = a; bus_we = 1'b1; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(logic [2:0] a, output logic [31:0] d);
    bus_addr = a;
    @(negedge clk);
    d = bus_rdata;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rd(3'd0, d); check("R1 pending", d, 32'd0);
    rd(3'd1, d); check("R1 disable", d, 32'd0);
    rd(3'd4, d); check("R1 target", d, 32'd0);
    check("R1 levels", {31'd0, |lvl_o}, 32'd0);
    check("R1 hw pend", {31'd0, |cpu_hw_pend_o}, 32'd0);
  endtask

  task automatic t_regs();
    logic [31:0] d;
    wr(3'd3, 32'hFFFF_FFFF);
    rd(3'd1, d); check("R5 mask all", d, 32'hF05D_FF80);
    rd(3'd1, d); check("R3 masked read", d & 32'h0FA2_007F, 32'd0);
    wr(3'd2, 32'hFFFF_FFFF);
    rd(3'd1, d); check("R4 enable all", d, 32'd0);
    wr(3'd3, 32'h0FA2_007F);
    rd(3'd1, d); check("R3 unimplemented ignored", d, 32'd0);
  endtask

  task automatic t_route();
    logic [31:0] d;
    src_i[7] = 1'b1;
    #1 check("R12 not before edge", lane(lvl_o, 0), 32'd0);
    step();
    check("R9 level 7 routed", lane(lvl_o, 0), lbit(7));
    check("R9 hw pend set", lane(cpu_hw_pend_o, 0), lbit(7));
    rd(3'd0, d); check("R2 pending bit 7", d, 32'h80);
    src_i[16] = 1'b1; step();
    check("R8 bit16 level 1", lane(lvl_o, 0), lbit(7) | lbit(16));
    src_i[7] = 1'b0; step();
    check("R9 fall clears level", lane(lvl_o, 0), lbit(16));
    check("R9 fall clears hw", lane(cpu_hw_pend_o, 0), lbit(16));
    rd(3'd0, d); check("R9 fall clears pending", d, 32'h0001_0000);
    src_i[16] = 1'b0; step();
    src_i[0] = 1'b1; step();
    rd(3'd0, d); check("R8 level0 no pending", d, 32'd0);
    check("R8 level0 no output", {31'd0, |lvl_o}, 32'd0);
    src_i[0] = 1'b0; step();
  endtask

  task automatic t_target();
    logic [31:0] d;
    wr(3'd4, 32'h15);
    rd(3'd4, d); check("R6 low 4 bits", d, 32'd5);
    src_i[22] = 1'b1; step();
    check("R7 target gets level", lane(lvl_o, 5), lbit(22));
    check("R7 old target empty", lane(lvl_o, 0), 32'd0);
    check("R9 target hw pend", lane(cpu_hw_pend_o, 5), lbit(22));
    check("R9 other hw pend", lane(cpu_hw_pend_o, 0), 32'd0);
  endtask

  task automatic t_gdis();
    logic [31:0] d;
    wr(3'd3, 32'h8000_0000);
    check("R7 global disable", lane(lvl_o, 5), 32'd0);
    rd(3'd0, d); check("R7 pending kept", d, 32'h0040_0000);
    wr(3'd2, 32'h8000_0000);
    check("R7 global enable", lane(lvl_o, 5), lbit(22));
  endtask

  task automatic t_disable();
    logic [31:0] d;
    wr(3'd3, 32'h0040_0000);
    check("R5 disable drops level", lane(lvl_o, 5), 32'd0);
    rd(3'd0, d); check("R5 pending cleared", d, 32'd0);
    wr(3'd2, 32'h0040_0000);
    check("R4 enable no revive", lane(lvl_o, 5), 32'd0);
    src_i[22] = 1'b0; step();
    src_i[22] = 1'b1; step();
    check("R9 new rise routes", lane(lvl_o, 5), lbit(22));
    wr(3'd3, 32'h0040_0000);
    src_i[22] = 1'b0; step();
    src_i[22] = 1'b1; step();
    rd(3'd0, d); check("R7 disabled still pends", d, 32'h0040_0000);
    check("R7 disabled not routed", lane(lvl_o, 5), 32'd0);
    wr(3'd2, 32'h0040_0000);
    check("R4 enable routes pending", lane(lvl_o, 5), lbit(22));
    src_i[22] = 1'b0; step();
    check("R9 cleared", lane(lvl_o, 5), 32'd0);
  endtask

  task automatic t_soft();
    soft_i[3*LN +: LN] = 15'h5555;
    soft_i[5*LN +: LN] = 15'h0100;
    src_i[28] = 1'b1;
    step();
    check("R10 soft non-target", lane(lvl_o, 3), 32'h5555);
    check("R10 soft merged", lane(lvl_o, 5), 32'h0100 | lbit(28));
    soft_i = '0; src_i[28] = 1'b0; step();
    check("R10 soft removed", lane(lvl_o, 3), 32'd0);
  endtask

  task automatic t_timer();
    logic [31:0] d;
    tmr_i[2] = 1'b1; step();
    check("R11 timer hw pend", lane(cpu_hw_pend_o, 2), 32'h2000);
    check("R11 timer routed to target", lane(lvl_o, 5), 32'h2000);
    check("R11 timer owner no route", lane(lvl_o, 2), 32'd0);
    rd(3'd0, d); check("R11 timer pending bit", d, 32'h4000);
    tmr_i[2] = 1'b0; step();
    check("R11 timer fall hw", lane(cpu_hw_pend_o, 2), 32'd0);
    rd(3'd0, d); check("R11 timer fall pending", d, 32'd0);
  endtask

  task automatic t_conflict();
    logic [31:0] d;
    src_i[29] = 1'b1;
    wr(3'd3, 32'h2000_0000);
    rd(3'd0, d); check("R13 write wins", d, 32'd0);
    check("R13 no level", lane(lvl_o, 5), 32'd0);
    wr(3'd2, 32'h2000_0000);
    src_i[29] = 1'b0; step();
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(4 * 200000);
    checks++; fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_regs();
    t_route();
    t_target();
    t_gdis();
    t_disable();
    t_soft();
    t_timer();
    t_conflict();
    finish_run();
  end
endmodule